// File: doc/BRIEF.md
# Serialized Interrupt Frame Slave

This block is the peripheral end of a shared, single-wire serialized interrupt channel that runs on the PCI clock. It watches the host open a frame by holding the line low. After that low run it counts 21 fixed interrupt slots. In the slots it owns, it drives the current levels of its interrupt sources. It then measures the closing low run (the stop frame) to learn whether the next frame is host-paced (continuous) or requested by a slave (quiet). In quiet mode, when one of its owned levels changes, it pulls the idle line low for one clock to ask the host for a frame.

The sources are sixteen ISA IRQ levels, an SMI request, an IOCHCK request, and one interrupt level from each of three internal functions. The function interrupts are first folded onto the PCI lines INTA to INTD, following two tie controls. A two-bit mode select then decides two things: which groups go out in serial slots, and whether INTA to INTC appear on dedicated active-low parallel outputs.

The engine is a five-state machine:
- IDLE: the line is quiet.
- REQ: one clock in which the slave requests a start frame.
- START: the start frame's low run is being counted.
- SLOT: stepping through the slots. Each slot has a sample phase, a recovery phase and a turnaround phase.
- STOP: the stop frame's low run is being counted.

The transitions are:
- IDLE to START, on a low line.
- IDLE to REQ, in quiet mode when an owned level has changed.
- REQ to START, always.
- START to SLOT, on the first high clock after 4 to 8 low clocks.
- START to IDLE, on the first high clock after any other number of low clocks.
- SLOT to SLOT, from phase to phase and from slot to slot.
- SLOT to STOP, after the turnaround phase of the last slot.
- STOP to IDLE, on the first high clock after two or more low clocks.

Top module: `sirq_slave`

## Requirements
- R1: While reset is held and afterwards until the first frame, the slave does not drive the line: `sirq_oe`=0 and `sirq_o`=1. The mode after reset is continuous. With all function interrupts low, `inta_n`, `intb_n` and `intc_n` are all 1.
- R2: A start frame is a run of 4 to 8 low clocks, and any width in that range is accepted. The sample phase of slot 0 is the second clock after the line returns high.
- R3: A low run of 3 clocks, or of 9 clocks or more, is not a start frame. No slot is driven after it.
- R4: Each slot lasts 3 clocks: sample, recovery, turnaround. The slot order is:
  - slot 0: IRQ0
  - slot 1: IRQ1
  - slot 2: SMI. `irq_req[2]` is ignored.
  - slots 3 to 15: IRQ3 to IRQ15
  - slot 16: IOCHCK
  - slots 17 to 20: INTA, INTB, INTC, INTD
  
  In the sample phase of an owned slot, the slave drives low (`sirq_oe`=1, `sirq_o`=0) when that source is asserted (input high). Otherwise it leaves the line released.
- R5: In the recovery phase of every owned slot, the slave drives high for exactly one clock (`sirq_oe`=1, `sirq_o`=1). It releases the line in the turnaround phase. It never drives slots it does not own.
- R6: A stop frame of exactly 2 low clocks selects quiet mode. A stop frame of 3 or more low clocks selects continuous mode.
- R7: In quiet mode, when an owned slot level changes while the line is idle, the slave drives low for exactly one clock, on the clock after the change. It then releases the line. A start frame that the host extends from that clock is accepted.
- R8: In continuous mode, a level change causes no drive on an idle line.
- R9: With `int_mode`=0 (parallel PCI only), no slot is owned. The folded INTA, INTB and INTC levels appear inverted on `inta_n`, `intb_n` and `intc_n`.
- R10: With `int_mode`=1, slots 0 to 16 are owned and slots 17 to 20 are not. The parallel outputs behave as in R9.
- R11: With `int_mode`=2 or 3, all 21 slots are owned. `inta_n`, `intb_n` and `intc_n` are held at 1.
- R12: With `tie_cb`=1 and `tie_all`=0, INTA is function 0 OR function 1, INTB is 0, and INTC is function 2. Without ties, functions 0, 1 and 2 map to INTA, INTB and INTC. INTD is always 0.
- R13: With `tie_all`=1, INTA is the OR of all three functions, and INTB and INTC are 0. This holds whatever `tie_cb` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| sirq_i | input | 1 | Sampled level of the shared serial line |
| irq_req | input | 16 | ISA IRQ levels, active high; bit 2 unused |
| smi_req | input | 1 | SMI request, sent in slot 2 |
| iochck_req | input | 1 | IOCHCK request, sent in slot 16 |
| fn_int | input | 3 | Interrupt level of functions 0 to 2 |
| int_mode | input | 2 | 0 parallel PCI, 1 parallel PCI + serial ISA, 2/3 all serial |
| tie_cb | input | 1 | Fold functions 0 and 1 onto INTA |
| tie_all | input | 1 | Fold all functions onto INTA |
| sirq_oe | output | 1 | Drive enable for the serial line |
| sirq_o | output | 1 | Value driven when enabled |
| inta_n | output | 1 | Parallel INTA, active low |
| intb_n | output | 1 | Parallel INTB, active low |
| intc_n | output | 1 | Parallel INTC, active low |

## Verification
A slot counter that is out by one slot or one phase moves every low pulse and every high recovery pulse to the wrong clock of the frame. The first owned slot after the start frame already shows this at the ports. A start-width counter that saturates or compares wrongly makes the slave drive after an invalid start frame, or stay silent after a valid one, within two clocks of the line going high. A stuck quiet/continuous flag is visible on the first idle clock after an input change: an unwanted one-clock low, or a missing one. Wrong folding or mode decode shows at once on the parallel pins, and in the affected slots of the next frame.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int ISA_IRQS   = 16;
    localparam int NUM_FUNCS  = 3;
    localparam int NUM_PCI    = 4;
    localparam int NUM_PAR    = 3;
    localparam int NUM_SLOTS  = ISA_IRQS + 1 + NUM_PCI;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int SLOT_SMI   = 2;
    localparam int SLOT_IOCHK = ISA_IRQS;
    localparam int SLOT_PCI0  = ISA_IRQS + 1;

    localparam logic [1:0] MODE_PAR_PCI = 2'd0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_START,
        S_SLOT,
        S_STOP
    } sirq_state_t;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOVER,
        PH_TURN
    } sirq_phase_t;
endpackage

// File: rtl/sirq_route.sv
module sirq_route
    import sirq_pkg::*;
(
    input  logic [ISA_IRQS-1:0]  irq_req,
    input  logic                 smi_req,
    input  logic                 iochck_req,
    input  logic [NUM_FUNCS-1:0] fn_int,
    input  logic [1:0]           int_mode,
    input  logic                 tie_cb,
    input  logic                 tie_all,
    output logic [NUM_SLOTS-1:0] slot_req,
    output logic [NUM_SLOTS-1:0] slot_own,
    output logic [NUM_PAR-1:0]   par_int_n
);
    logic [NUM_PCI-1:0] pci_lvl;
    logic               isa_ser;
    logic               pci_ser;
    logic               unused_irq2;

    // fold function interrupts onto the PCI lines
    always_comb begin
        pci_lvl = '0;
        if (tie_all) begin
            pci_lvl[0] = |fn_int;
        end else if (tie_cb) begin
            pci_lvl[0] = fn_int[0] | fn_int[1];
            pci_lvl[2] = fn_int[2];
        end else begin
            pci_lvl[NUM_FUNCS-1:0] = fn_int;
        end
    end

    for (genvar g = 0; g < ISA_IRQS; g++) begin : g_isa
        if (g == SLOT_SMI) begin : g_smi
            assign slot_req[g] = smi_req;
        end else begin : g_irq
            assign slot_req[g] = irq_req[g];
        end
    end

    assign unused_irq2 = irq_req[SLOT_SMI];
    assign slot_req[SLOT_IOCHK]           = iochck_req;
    assign slot_req[SLOT_PCI0 +: NUM_PCI] = pci_lvl;

    assign isa_ser  = (int_mode != MODE_PAR_PCI);
    assign pci_ser  = int_mode[1];
    assign slot_own = {{NUM_PCI{pci_ser}}, {(ISA_IRQS + 1){isa_ser}}};

    assign par_int_n = pci_ser ? '1 : ~pci_lvl[NUM_PAR-1:0];
endmodule

// File: rtl/sirq_fsm.sv
module sirq_fsm
    import sirq_pkg::*;
#(
    parameter int START_MIN = 4,
    parameter int START_MAX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic [NUM_SLOTS-1:0] slot_own,
    output logic                 drv_oe,
    output logic                 drv_o
);
    localparam int CNT_W = $clog2(START_MAX + 2);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_SAT   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0]  MIN_C     = CNT_W'(START_MIN);
    localparam logic [CNT_W-1:0]  MAX_C     = CNT_W'(START_MAX);
    localparam logic [CNT_W-1:0]  STOP_Q    = CNT_W'(2);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    sirq_state_t          state_q, state_d;
    sirq_phase_t          ph_q, ph_d;
    logic [SLOT_W-1:0]    slot_q, slot_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic                 quiet_q, quiet_d;
    logic                 pend_q, pend_d;
    logic [NUM_SLOTS-1:0] prev_q, vec;
    logic                 change;
    logic                 oe_d, o_d;

    assign vec    = slot_req & slot_own;
    assign change = (vec != prev_q) && (|slot_own);

    // next-state logic
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q;
        slot_d  = slot_q;
        cnt_d   = cnt_q;
        quiet_d = quiet_q;
        pend_d  = pend_q | change;
        unique case (state_q)
            S_IDLE: begin
                if (!line_i) begin
                    state_d = S_START;
                    cnt_d   = CNT_ONE;
                end else if (quiet_q && pend_d) begin
                    state_d = S_REQ;
                    pend_d  = 1'b0;
                end
            end
            S_REQ: begin
                state_d = S_START;
                cnt_d   = CNT_ONE;
            end
            S_START: begin
                if (!line_i) begin
                    cnt_d = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
                end else if (cnt_q >= MIN_C && cnt_q <= MAX_C) begin
                    state_d = S_SLOT;
                    slot_d  = '0;
                    ph_d    = PH_SAMPLE;
                    pend_d  = change;
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_SLOT: begin
                unique case (ph_q)
                    PH_SAMPLE:  ph_d = PH_RECOVER;
                    PH_RECOVER: ph_d = PH_TURN;
                    PH_TURN: begin
                        if (slot_q == LAST_SLOT) begin
                            state_d = S_STOP;
                            cnt_d   = '0;
                        end else begin
                            slot_d = slot_q + 1'b1;
                            ph_d   = PH_SAMPLE;
                        end
                    end
                    default: ph_d = PH_SAMPLE;
                endcase
            end
            S_STOP: begin
                if (!line_i) begin
                    cnt_d = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
                end else if (cnt_q >= STOP_Q) begin
                    quiet_d = (cnt_q == STOP_Q);
                    state_d = S_IDLE;
                end else begin
                    cnt_d = '0;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ph_q    <= PH_SAMPLE;
            slot_q  <= '0;
            cnt_q   <= '0;
            quiet_q <= 1'b0;
            pend_q  <= 1'b0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            slot_q  <= slot_d;
            cnt_q   <= cnt_d;
            quiet_q <= quiet_d;
            pend_q  <= pend_d;
            prev_q  <= vec;
        end
    end

    // output decode for the coming clock
    always_comb begin
        oe_d = 1'b0;
        o_d  = 1'b1;
        if (state_d == S_REQ) begin
            oe_d = 1'b1;
            o_d  = 1'b0;
        end else if (state_d == S_SLOT && slot_own[slot_d]) begin
            if (ph_d == PH_SAMPLE && slot_req[slot_d]) begin
                oe_d = 1'b1;
                o_d  = 1'b0;
            end else if (ph_d == PH_RECOVER) begin
                oe_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_oe <= 1'b0;
            drv_o  <= 1'b1;
        end else begin
            drv_oe <= oe_d;
            drv_o  <= o_d;
        end
    end
endmodule

// File: rtl/sirq_slave.sv
module sirq_slave
    import sirq_pkg::*;
#(
    parameter int START_MIN = 4,
    parameter int START_MAX = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sirq_i,
    input  logic [15:0] irq_req,
    input  logic        smi_req,
    input  logic        iochck_req,
    input  logic [2:0]  fn_int,
    input  logic [1:0]  int_mode,
    input  logic        tie_cb,
    input  logic        tie_all,
    output logic        sirq_oe,
    output logic        sirq_o,
    output logic        inta_n,
    output logic        intb_n,
    output logic        intc_n
);
    logic [NUM_SLOTS-1:0] slot_req;
    logic [NUM_SLOTS-1:0] slot_own;
    logic [NUM_PAR-1:0]   par_int_n;

    sirq_route route_i (
        .irq_req   (irq_req),
        .smi_req   (smi_req),
        .iochck_req(iochck_req),
        .fn_int    (fn_int),
        .int_mode  (int_mode),
        .tie_cb    (tie_cb),
        .tie_all   (tie_all),
        .slot_req  (slot_req),
        .slot_own  (slot_own),
        .par_int_n (par_int_n)
    );

    sirq_fsm #(
        .START_MIN(START_MIN),
        .START_MAX(START_MAX)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (sirq_i),
        .slot_req(slot_req),
        .slot_own(slot_own),
        .drv_oe  (sirq_oe),
        .drv_o   (sirq_o)
    );

    assign inta_n = par_int_n[0];
    assign intb_n = par_int_n[1];
    assign intc_n = par_int_n[2];
endmodule

// File: rtl/sirq_slave_chk.sv
module sirq_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sirq_oe,
    input logic       sirq_o,
    input logic [1:0] int_mode,
    input logic       tie_all,
    input logic       inta_n,
    input logic       intb_n,
    input logic       intc_n
);
    // recovery drive lasts one clock, turnaround follows released
    assert_recovery_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && sirq_o) |=> !sirq_oe);

    // a low drive never lasts beyond one clock
    assert_single_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe && !sirq_o) |=> (!sirq_oe || sirq_o));

    // parallel-only mode keeps the serial line untouched
    assert_mode0_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode == 2'd0 && $past(int_mode) == 2'd0) |-> !sirq_oe);

    // fully serial mode parks the parallel pins
    assert_serial_pins_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode[1] |-> (inta_n && intb_n && intc_n));

    // tie-all leaves only INTA in use
    assert_tie_all_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tie_all |-> (intb_n && intc_n));
endmodule

bind sirq_slave sirq_slave_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sirq_oe (sirq_oe),
    .sirq_o  (sirq_o),
    .int_mode(int_mode),
    .tie_all (tie_all),
    .inta_n  (inta_n),
    .intb_n  (intb_n),
    .intc_n  (intc_n)
);

// File: tb/sirq_slave_tb_top.sv
module sirq_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_low = 1'b0;
    logic [15:0] irq_req = '0;
    logic        smi_req = 1'b0;
    logic        iochck_req = 1'b0;
    logic [2:0]  fn_int = '0;
    logic [1:0]  int_mode = 2'd1;
    logic        tie_cb = 1'b0;
    logic        tie_all = 1'b0;
    wire         sirq_oe, sirq_o, inta_n, intb_n, intc_n;
    wire         sirq_line = host_low ? 1'b0 : (sirq_oe ? sirq_o : 1'b1);

    always #(CLK_PERIOD / 2) clk = ~clk;

    sirq_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sirq_i(sirq_line),
        .irq_req(irq_req), .smi_req(smi_req), .iochck_req(iochck_req),
        .fn_int(fn_int), .int_mode(int_mode), .tie_cb(tie_cb), .tie_all(tie_all),
        .sirq_oe(sirq_oe), .sirq_o(sirq_o),
        .inta_n(inta_n), .intb_n(intb_n), .intc_n(intc_n)
    );

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    int    mk_kind = 0;
    string mk_tag = "R1";
    bit    own_q[$];
    bit    low_q[$];
    string tag_q[$];
    bit    cur_own = 1'b0;
    string cur_tag = "R4";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    function automatic bit exp_pci(int i);
        bit [3:0] p = '0;
        if (tie_all) p[0] = |fn_int;
        else if (tie_cb) begin
            p[0] = fn_int[0] | fn_int[1];
            p[2] = fn_int[2];
        end else p[2:0] = fn_int;
        return p[i];
    endfunction

    function automatic bit exp_req(int s);
        if (s == 2) return smi_req;
        if (s < 16) return irq_req[s];
        if (s == 16) return iochck_req;
        return exp_pci(s - 17);
    endfunction

    function automatic bit exp_own(int s);
        if (s < 17) return int_mode != 2'd0;
        return int_mode[1];
    endfunction

    // one bus clock: host line drive plus the kind of check for this clock
    task automatic cyc(input bit low, input int kind, input string tag);
        @(posedge clk);
        #1;
        host_low = low;
        mk_kind  = kind;
        mk_tag   = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1, tag);
    endtask

    task automatic pins(input string tag, input logic [2:0] exp_v);
        @(posedge clk);
        #2;
        check(tag, {inta_n, intb_n, intc_n}, exp_v);
    endtask

    // driver: pushes expected slot items, then plays the host side of a frame
    task automatic frame(input int w, input int stop_w, input bit dut_started,
                         input bit accept, input string tag);
        if (accept) begin
            for (int s = 0; s < NSLOT; s++) begin
                own_q.push_back(exp_own(s));
                low_q.push_back(exp_own(s) && exp_req(s));
                tag_q.push_back(tag);
            end
        end
        for (int i = 0; i < (dut_started ? w - 1 : w); i++) cyc(1'b1, 1, tag);
        cyc(1'b0, 1, tag);
        if (accept) begin
            for (int s = 0; s < NSLOT; s++) begin
                cyc(1'b0, 2, tag);
                cyc(1'b0, 3, tag);
                cyc(1'b0, 4, tag);
            end
            for (int i = 0; i < stop_w; i++) cyc(1'b1, 1, tag);
            idle(3, tag);
            check(tag, own_q.size(), 0);
        end else begin
            idle(70, tag);
        end
    endtask

    // monitor: compares the line drive of each clock with what was queued
    always @(negedge clk) begin
        case (mk_kind)
            1: check(mk_tag, {sirq_oe, sirq_o}, 2'b01);
            2: begin
                if (own_q.size() == 0) begin
                    check(mk_tag, 32'hdead, 0);
                end else begin
                    bit lo;
                    cur_own = own_q.pop_front();
                    lo      = low_q.pop_front();
                    cur_tag = tag_q.pop_front();
                    check(cur_tag, {sirq_oe, sirq_o}, lo ? 2'b10 : 2'b01);
                end
            end
            3: check({cur_tag, "/R5"}, {sirq_oe, sirq_o}, cur_own ? 2'b11 : 2'b01);
            4: check({cur_tag, "/R5"}, {sirq_oe, sirq_o}, 2'b01);
            5: check(mk_tag, {sirq_oe, sirq_o}, 2'b10);
            default: ;
        endcase
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3, "R1");
        pins("R1", 3'b111);
        @(posedge clk);
        #1 rst_n = 1'b1;
        idle(3, "R1");

        // R8: continuous after reset, a change gives no request
        irq_req[3] = 1'b1;
        idle(6, "R8");

        // R2, R4, R11: fully serial, two start widths
        int_mode   = 2'd2;
        irq_req    = 16'hA5A4;
        iochck_req = 1'b1;
        fn_int     = 3'b010;
        pins("R11", 3'b111);
        frame(4, 3, 1'b0, 1'b1, "R2");
        irq_req    = 16'h5A1B;
        smi_req    = 1'b1;
        iochck_req = 1'b0;
        fn_int     = 3'b101;
        frame(8, 3, 1'b0, 1'b1, "R4");
        int_mode   = 2'd3;
        irq_req    = 16'hFFFF;
        frame(6, 3, 1'b0, 1'b1, "R5");

        // R3: invalid start widths
        frame(3, 0, 1'b0, 1'b0, "R3");
        frame(9, 0, 1'b0, 1'b0, "R3");

        // R10: serial ISA with parallel PCI
        int_mode = 2'd1;
        fn_int   = 3'b101;
        irq_req  = 16'h8001;
        smi_req  = 1'b0;
        pins("R10", 3'b010);
        frame(5, 3, 1'b0, 1'b1, "R10");

        // R9: parallel only
        int_mode = 2'd0;
        fn_int   = 3'b011;
        pins("R9", 3'b001);
        frame(4, 3, 1'b0, 1'b1, "R9");

        // R12: card-function tie
        int_mode = 2'd1;
        tie_cb   = 1'b1;
        fn_int   = 3'b010;
        pins("R12", 3'b011);
        fn_int   = 3'b100;
        pins("R12", 3'b110);
        int_mode = 2'd2;
        fn_int   = 3'b010;
        frame(4, 3, 1'b0, 1'b1, "R12");

        // R13: tie-all overrides
        tie_all  = 1'b1;
        int_mode = 2'd1;
        fn_int   = 3'b100;
        pins("R13", 3'b011);
        int_mode = 2'd2;
        frame(4, 3, 1'b0, 1'b1, "R13");
        tie_all  = 1'b0;
        tie_cb   = 1'b0;

        // R6: two-clock stop frame gives quiet mode
        irq_req = 16'h0010;
        fn_int  = 3'b000;
        frame(4, 2, 1'b0, 1'b1, "R6");
        idle(4, "R6");

        // R7: quiet-mode request then host-extended frame
        @(posedge clk);
        #1;
        irq_req[7] = 1'b1;
        host_low   = 1'b0;
        mk_kind    = 1;
        mk_tag     = "R7";
        cyc(1'b0, 5, "R7");
        frame(4, 3, 1'b1, 1'b1, "R7");

        // R6: three-clock stop restored continuous mode
        @(posedge clk);
        #1;
        irq_req[7] = 1'b0;
        idle(6, "R6");

        mk_kind = 0;
        done    = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule